// File: doc/BRIEF.md
# Read-Triggered Clock Stop Controller

This block is an 8-bit I/O trigger register. It sits at offset 14h above a programmable power-management base address. It stores no data. Any read of it returns zero. The same read asks the processor clock logic to drop into the level-2 (C2) power state.

On entry to C2 the controller drives the active-low stop-clock output low. The output stays low until a break event arrives. Writes to the register do nothing.

Outside C2, a throttle engine can stop the clock for part of every 16-cycle window. Two sources can request throttling:
- an enable input, which uses a programmable duty value;
- a thermal override input, which uses a fixed duty value.

While the controller is in C2, neither throttle source has any say over the output.

Top module: `clkstop_ctrl`

## Requirements
- R1: A read hits the register only when `io_addr` equals `io_base + 14h`. A read at any other address leaves `stpclk_n` untouched.
- R2: `io_rdata` is 8'h00 for every read, and at all other times.
- R3: A write strobe at the register address has no effect. With no throttle request, `stpclk_n` stays 1.
- R4: A read hit in cycle N enters C2. `stpclk_n` is 0 from cycle N+1 on.
- R5: Once in C2, `stpclk_n` stays 0 in every cycle until a break event is seen.
- R6: A `brk_evt` high in a C2 cycle ends C2, and `stpclk_n` returns to 1 in the next cycle. If `brk_evt` is already high during the read hit, `stpclk_n` is low for exactly one cycle.
- R7: While in C2, throttle requests are ignored and `stpclk_n` is held at 0 without a gap. The throttle phase is held at 0, so the first cycle after C2 ends is phase 0.
- R8: Outside C2, with `thr_en` high and `therm_ovr` low, a 16-cycle phase count runs. The phase starts at 0 in the first requesting cycle. `stpclk_n` is 0 exactly in the phases below `thr_duty`, so duty 0 never stops the clock.
- R9: `therm_ovr` high takes priority over `thr_en` and `thr_duty`. It throttles with a fixed duty of 8 phases out of 16.
- R10: A synchronous active-high `rst` clears C2 and the phase count. After reset, `stpclk_n` is 1 when no throttle is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_base | input | 16 | Power-management base address |
| io_addr | input | 16 | I/O access address |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rdata | output | 8 | Read data, always zero |
| brk_evt | input | 1 | Break event, ends C2 |
| thr_en | input | 1 | Throttle enable |
| therm_ovr | input | 1 | Thermal override throttle request |
| thr_duty | input | 4 | Stopped phases per 16-cycle window for `thr_en` throttling |
| stpclk_n | output | 1 | Active-low stop-clock request |

## Verification
The bench builds the block with its defaults:
- a 16-cycle throttle window, which gives a 4-bit duty;
- a thermal duty of 8;
- the register offset 14h, placed above a base address of 0400h.

The short window lets the bench drive several full throttle periods at duty 0, 5 and 15, which puts both duty extremes and the phase wrap within reach. It also lets the bench enter C2 in the middle of a throttle period and see the phase restart at 0 after the break.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_STOP = 1'b1
  } c_state_e;

  // Advance the throttle phase, wrapping at the window length.
  function automatic int unsigned next_phase(input int unsigned ph, input int unsigned period);
    return (ph + 1 >= period) ? 0 : ph + 1;
  endfunction

  // True when the current phase falls inside the stopped part of the window.
  function automatic logic phase_stopped(input int unsigned ph, input int unsigned duty);
    return ph < duty;
  endfunction

endpackage

// File: rtl/clkstop_decode.sv
module clkstop_decode #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int REG_OFS = 32'h14
) (
  input  logic [ADDR_W-1:0] io_base,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  output logic              rd_hit,
  output logic              wr_hit,
  output logic [DATA_W-1:0] rdata
);
  logic [ADDR_W-1:0] reg_addr;
  logic              match;

  assign reg_addr = io_base + ADDR_W'(REG_OFS);
  assign match    = (io_addr == reg_addr);
  assign rd_hit   = io_rd & match;
  assign wr_hit   = io_wr & match;
  assign rdata    = '0;
endmodule

// File: rtl/clkstop_c2_fsm.sv
module clkstop_c2_fsm
  import clkstop_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rd_hit,
  input  logic brk_evt,
  output logic in_c2,
  output logic c2_enter,
  output logic c2_leave
);
  c_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (rd_hit)
      state_d = ST_STOP;
    else if (state_q == ST_STOP && brk_evt)
      state_d = ST_RUN;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_RUN;
    else     state_q <= state_d;
  end

  assign in_c2    = (state_q == ST_STOP);
  assign c2_enter = (state_q == ST_RUN)  && (state_d == ST_STOP);
  assign c2_leave = (state_q == ST_STOP) && (state_d == ST_RUN);
endmodule

// File: rtl/clkstop_throttle.sv
module clkstop_throttle
  import clkstop_pkg::*;
#(
  parameter int PERIOD     = 16,
  parameter int THERM_DUTY = 8,
  localparam int PH_W      = $clog2(PERIOD)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hold,
  input  logic            in_c2,
  input  logic            thr_en,
  input  logic            therm_ovr,
  input  logic [PH_W-1:0] duty,
  output logic [PH_W-1:0] phase,
  output logic            thr_req,
  output logic            thr_stop
);
  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] duty_eff;

  assign thr_req  = thr_en | therm_ovr;
  assign duty_eff = therm_ovr ? PH_W'(THERM_DUTY) : duty;

  always_ff @(posedge clk) begin
    if (rst)
      phase_q <= '0;
    else if (!thr_req || hold)
      phase_q <= '0;
    else
      phase_q <= PH_W'(next_phase(32'(phase_q), PERIOD));
  end

  assign phase    = phase_q;
  assign thr_stop = thr_req & ~in_c2 & phase_stopped(32'(phase_q), 32'(duty_eff));
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int REG_OFS    = 32'h14,
  parameter int PERIOD     = 16,
  parameter int THERM_DUTY = 8,
  localparam int PH_W      = $clog2(PERIOD)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_base,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  output logic [DATA_W-1:0] io_rdata,
  input  logic              brk_evt,
  input  logic              thr_en,
  input  logic              therm_ovr,
  input  logic [PH_W-1:0]   thr_duty,
  output logic              stpclk_n
);
  // Named internal events, visible to the bound checker.
  logic            rd_hit;
  logic            wr_hit;
  logic            in_c2;
  logic            c2_enter;
  logic            c2_leave;
  logic [PH_W-1:0] thr_phase;
  logic            thr_req;
  logic            thr_stop;

  clkstop_decode #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .REG_OFS(REG_OFS)
  ) u_dec (
    .io_base(io_base),
    .io_addr(io_addr),
    .io_rd  (io_rd),
    .io_wr  (io_wr),
    .rd_hit (rd_hit),
    .wr_hit (wr_hit),
    .rdata  (io_rdata)
  );

  clkstop_c2_fsm u_c2 (
    .clk     (clk),
    .rst     (rst),
    .rd_hit  (rd_hit),
    .brk_evt (brk_evt),
    .in_c2   (in_c2),
    .c2_enter(c2_enter),
    .c2_leave(c2_leave)
  );

  clkstop_throttle #(
    .PERIOD    (PERIOD),
    .THERM_DUTY(THERM_DUTY)
  ) u_thr (
    .clk      (clk),
    .rst      (rst),
    .hold     (in_c2 | rd_hit),
    .in_c2    (in_c2),
    .thr_en   (thr_en),
    .therm_ovr(therm_ovr),
    .duty     (thr_duty),
    .phase    (thr_phase),
    .thr_req  (thr_req),
    .thr_stop (thr_stop)
  );

  assign stpclk_n = ~(in_c2 | thr_stop);
endmodule

// File: rtl/clkstop_checker.sv
module clkstop_checker #(
  parameter int PH_W   = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_hit,
  input logic              wr_hit,
  input logic              brk_evt,
  input logic              in_c2,
  input logic              c2_enter,
  input logic              c2_leave,
  input logic              thr_req,
  input logic [PH_W-1:0]   thr_phase,
  input logic [DATA_W-1:0] io_rdata,
  input logic              stpclk_n
);
  p_rdata_zero_r2: assert property (@(posedge clk) disable iff (rst)
    io_rdata == '0);

  p_enter_r4: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> (in_c2 && !stpclk_n));

  p_write_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && !rd_hit && !in_c2) |=> !in_c2);

  p_no_stray_entry_r1: assert property (@(posedge clk) disable iff (rst)
    (!rd_hit && !in_c2) |=> !in_c2);

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (in_c2 && !brk_evt && !rd_hit) |=> (in_c2 && !stpclk_n));

  p_exit_r6: assert property (@(posedge clk) disable iff (rst)
    (in_c2 && brk_evt && !rd_hit) |=> !in_c2);

  p_events_r6: assert property (@(posedge clk) disable iff (rst)
    !(c2_enter && c2_leave));

  p_no_throttle_r7: assert property (@(posedge clk) disable iff (rst)
    in_c2 |-> (thr_phase == '0 && !stpclk_n));

  p_idle_phase_r8: assert property (@(posedge clk) disable iff (rst)
    !thr_req |=> (thr_phase == '0));
endmodule

bind clkstop_ctrl clkstop_checker #(
  .PH_W  (PH_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rd_hit   (rd_hit),
  .wr_hit   (wr_hit),
  .brk_evt  (brk_evt),
  .in_c2    (in_c2),
  .c2_enter (c2_enter),
  .c2_leave (c2_leave),
  .thr_req  (thr_req),
  .thr_phase(thr_phase),
  .io_rdata (io_rdata),
  .stpclk_n (stpclk_n)
);

// File: tb/test_clkstop_ctrl.sv
`timescale 1ns/1ps
module test_clkstop_ctrl;
  localparam logic [15:0] BASE  = 16'h0400;
  localparam logic [15:0] TRIG  = BASE + 16'h0014;
  localparam int          WIN   = 16;
  localparam int          THERM = 8;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] io_addr;
  logic        io_rd, io_wr;
  logic [7:0]  io_rdata;
  logic        brk_evt, thr_en, therm_ovr;
  logic [3:0]  thr_duty;
  logic        stpclk_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  clkstop_ctrl i_clkstop_ctrl (
    .clk      (clk),
    .rst      (rst),
    .io_base  (BASE),
    .io_addr  (io_addr),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .io_rdata (io_rdata),
    .brk_evt  (brk_evt),
    .thr_en   (thr_en),
    .therm_ovr(therm_ovr),
    .thr_duty (thr_duty),
    .stpclk_n (stpclk_n)
  );

  typedef struct {
    logic  stp_n;
    string tag;
  } exp_t;

  exp_t q[$];

  // Reference state, kept from the requirements.
  bit m_c2  = 1'b0;
  int m_ph  = 0;

  // Push the expected output of the cycle now driven, then advance the model.
  task automatic step(input string tag);
    exp_t e;
    bit   req, hit;
    int   dsel;
    req  = thr_en | therm_ovr;
    dsel = therm_ovr ? THERM : int'(thr_duty);
    hit  = io_rd && (io_addr == TRIG);
    e.stp_n = !(m_c2 || (req && m_ph < dsel));
    e.tag   = tag;
    q.push_back(e);
    if (rst) begin
      m_c2 = 1'b0;
      m_ph = 0;
    end else begin
      m_ph = (!req || m_c2 || hit) ? 0 : (m_ph + 1) % WIN;
      if (hit)          m_c2 = 1'b1;
      else if (brk_evt) m_c2 = 1'b0;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic io_read(input logic [15:0] a, input string tag);
    io_addr = a; io_rd = 1'b1;
    step(tag);
    io_rd = 1'b0; io_addr = 16'h0000;
  endtask

  // Monitor: compare one scoreboard item per cycle, half a period after the edge.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (stpclk_n !== e.stp_n) begin
        errors++;
        $display("FAIL %s: stpclk_n actual %b expected %b", e.tag, stpclk_n, e.stp_n);
      end
      checks++;
      if (io_rdata !== 8'h00) begin
        errors++;
        $display("FAIL R2: io_rdata actual %h expected 00", io_rdata);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run not finished, actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; io_addr = '0; io_rd = 1'b0; io_wr = 1'b0;
    brk_evt = 1'b0; thr_en = 1'b0; therm_ovr = 1'b0; thr_duty = '0;
    @(posedge clk); #1;
    idle(3, "R10 reset");
    rst = 1'b0;
    idle(3, "R10 after reset");

    // R1: near-miss addresses do not trigger
    io_read(TRIG + 16'h1, "R1 addr+1");
    io_read(TRIG - 16'h1, "R1 addr-1");
    io_read(16'h0014, "R1 offset without base");
    idle(3, "R1 no entry");

    // R3: write at the register address
    io_addr = TRIG; io_wr = 1'b1;
    step("R3 write");
    io_wr = 1'b0; io_addr = '0;
    idle(3, "R3 write ignored");

    // R4/R5/R6: entry, hold, break
    io_read(TRIG, "R4 read cycle");
    step("R4 first stop cycle");
    idle(6, "R5 holding");
    brk_evt = 1'b1;
    step("R6 break cycle");
    brk_evt = 1'b0;
    idle(3, "R6 released");

    // R6: break already present during the read
    brk_evt = 1'b1;
    io_read(TRIG, "R6 read with break");
    step("R6 one-cycle stop");
    idle(2, "R6 released after one cycle");
    brk_evt = 1'b0;
    idle(2, "R6 idle");

    // R8: throttle at duty 5, 0, 15
    thr_en = 1'b1; thr_duty = 4'd5;
    idle(2 * WIN + 3, "R8 duty 5");
    thr_en = 1'b0; idle(2, "R8 off");
    thr_en = 1'b1; thr_duty = 4'd0;
    idle(WIN + 2, "R8 duty 0");
    thr_duty = 4'd15;
    thr_en = 1'b0; idle(1, "R8 off");
    thr_en = 1'b1;
    idle(2 * WIN + 1, "R8 duty 15");

    // R7: enter C2 mid-window while throttling, then restart from phase 0
    thr_duty = 4'd4;
    thr_en = 1'b0; idle(1, "R8 off");
    thr_en = 1'b1;
    idle(9, "R8 duty 4");
    io_read(TRIG, "R7 read while throttling");
    therm_ovr = 1'b1;
    idle(5, "R7 override ignored in C2");
    therm_ovr = 1'b0;
    idle(WIN + 2, "R7 steady stop");
    brk_evt = 1'b1; step("R7 break");
    brk_evt = 1'b0;
    idle(WIN + 4, "R7 restart at phase 0");

    // R9: thermal override priority
    thr_en = 1'b0; idle(1, "R9 off");
    thr_duty = 4'd3; thr_en = 1'b1; therm_ovr = 1'b1;
    idle(2 * WIN + 2, "R9 override duty");
    thr_en = 1'b0; thr_duty = 4'd0;
    idle(WIN + 1, "R9 override alone");
    therm_ovr = 1'b0;
    idle(2, "R9 off");

    // R10: reset while in C2
    io_read(TRIG, "R10 enter C2");
    idle(3, "R10 in C2");
    rst = 1'b1; step("R10 reset in C2");
    rst = 1'b0;
    idle(4, "R10 cleared");

    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule